// File: doc/BRIEF.md
# Clock Distributor Divider-Sync Sequencer

This block runs a fixed divider-alignment procedure on an external clock-distribution device. It writes the device's control registers over a write-only SPI link. The host picks two things: which outputs must have their dividers realigned (a bit mask), and the SYSREF source mode to leave behind once alignment is finished. The host then pulses `start`. The block takes a copy of all host inputs at that moment and issues nine register writes in a fixed order. The sync pulse itself is made in software: the device's sync polarity bit is raised and then lowered.

The block keeps a shadow byte for each of the three device registers it changes. Every field change is a read-modify-write of the matching shadow byte, followed by a write of the whole byte, so bits the procedure does not own keep their values. The shadows carry over from one run to the next. A small internal shifter generates the SPI clock at a programmable rate. A programmable idle gap separates consecutive writes. `busy` covers the whole run, and `done` pulses once at the end.

Top module: `csync_seq`

## Requirements
- R1: Each write is a 24-bit word sent MSB first. Bit 23 is the write flag and is always 0. Bits 22:8 carry the 15-bit register address (sync control 0x0140, SYSREF control 0x0141, per-output sync-disable 0x0142). Bits 7:0 carry the data byte.
- R2: SCLK idles low and chip select idles high. MOSI changes only on SCLK falling edges. Chip select stays low for exactly 24 SCLK rising edges per word. Each SCLK half period lasts max(`sclk_div`,1) clock cycles.
- R3: One run consists of exactly nine writes, in this order:
  - sync control: mode field [1:0]=1, polarity [2]=0, enable [3]=1
  - SYSREF control: mux [1:0]=0, power-down [2]=0
  - sync control: delay-clear bit [4]=1
  - sync-disable clear
  - polarity high
  - polarity low
  - sync-disable set
  - sync control: delay-clear bit [4]=0
  - SYSREF mux final
- R4: Every write changes only the fields named in R3. All other bits come from the shadow byte. Shadows reset to sync control 0x80, SYSREF control 0x44 and sync-disable 0xFF, and persist across runs.
- R5: Bit i of the sync-disable register belongs to output i. Write 4 clears exactly the masked bits. Write 7 sets them again.
- R6: The sync pulse is write 5 with polarity bit [2]=1, followed directly by write 6 with bit [2]=0.
- R7: The last write puts `sref_mode` into SYSREF control bits [1:0]. Modes are 1 = pin, 2 = pulser, 3 = continuous.
- R8: A `start` pulse while busy is ignored. Mask, mode, divider and gap are captured only when a start is accepted.
- R9: `busy` rises on the cycle after an accepted start. It stays high until the cycle in which `done` pulses for one cycle, which follows the completion of the ninth write.
- R10: Between consecutive writes, chip select stays high for at least max(`gap_len`,1) SPI clock periods.
- R11: After reset: `busy`=0, `done`=0, chip select high, SCLK low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, one cycle |
| out_mask | input | NUM_OUT | Outputs whose dividers are realigned |
| sref_mode | input | 2 | Final SYSREF mux mode |
| sclk_div | input | DIV_W | SCLK half period in clock cycles (0 treated as 1) |
| gap_len | input | GAP_W | Inter-write gap in SPI periods (0 treated as 1) |
| spi_sclk | output | 1 | SPI clock |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI serial data out |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest condition to reach is R4 with shadows that already differ from reset. Write values then depend on earlier runs, and a design that rebuilt each byte from constants would only be exposed on later runs. The bench therefore walks a table of runs back to back with overlapping and disjoint masks and different final modes, carrying its own shadow model from run to run. A second hard case is a start that arrives in the middle of a word. The bench waits until three words have been captured, then pulses start with a different mask, and checks that the run still holds exactly nine words built from the original mask and that no tenth frame follows.

// File: rtl/csync_pkg.sv
package csync_pkg;
   localparam int WORD_W   = 24;
   localparam int ADDR_W   = 15;
   localparam int N_WRITES = 9;
   localparam int IDX_W    = $clog2(N_WRITES);

   typedef enum logic [1:0] {
      REG_SYNC = 2'd0,
      REG_SREF = 2'd1,
      REG_SDIS = 2'd2
   } reg_sel_e;

   localparam logic [ADDR_W-1:0] ADDR_SYNC = 15'h0140;
   localparam logic [ADDR_W-1:0] ADDR_SREF = 15'h0141;
   localparam logic [ADDR_W-1:0] ADDR_SDIS = 15'h0142;

   // sync control fields
   localparam logic [7:0] SY_MODE_MASK = 8'h03;
   localparam logic [7:0] SY_MODE_PIN  = 8'h01;
   localparam logic [7:0] SY_POL       = 8'h04;
   localparam logic [7:0] SY_EN        = 8'h08;
   localparam logic [7:0] SY_DCLR      = 8'h10;
   // SYSREF control fields
   localparam logic [7:0] SR_MUX_MASK  = 8'h03;
   localparam logic [7:0] SR_PD        = 8'h04;
endpackage

// File: rtl/csync_spi_shift.sv
module csync_spi_shift
   import csync_pkg::*;
#(
   parameter int DIV_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic [WORD_W-1:0]   word,
   input  logic [DIV_W-1:0]    half_div,
   output logic                sclk,
   output logic                csn,
   output logic                mosi,
   output logic                fin
);
   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

   logic [DIV_W-1:0]  hp;
   logic [DIV_W-1:0]  tcnt;
   logic [BIT_W-1:0]  bits;
   logic [WORD_W-1:0] sh;
   logic              act;

   assign hp   = (half_div == '0) ? DIV_W'(1) : half_div;
   assign mosi = act & sh[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk <= 1'b0;
         csn  <= 1'b1;
         act  <= 1'b0;
         fin  <= 1'b0;
         tcnt <= '0;
         bits <= '0;
         sh   <= '0;
      end else begin
         fin <= 1'b0;
         if (go && !act) begin
            act  <= 1'b1;
            csn  <= 1'b0;
            sclk <= 1'b0;
            sh   <= word;
            tcnt <= '0;
            bits <= '0;
         end else if (act) begin
            if (tcnt == hp - DIV_W'(1)) begin
               tcnt <= '0;
               if (!sclk) begin
                  sclk <= 1'b1;
               end else begin
                  sclk <= 1'b0;
                  if (bits == LAST_BIT) begin
                     act <= 1'b0;
                     csn <= 1'b1;
                     fin <= 1'b1;
                  end else begin
                     bits <= bits + BIT_W'(1);
                     sh   <= {sh[WORD_W-2:0], 1'b0};
                  end
               end
            end else begin
               tcnt <= tcnt + DIV_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/csync_step_ctrl.sv
module csync_step_ctrl
   import csync_pkg::*;
#(
   parameter int GCW = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [GCW-1:0]   gap_cyc,
   input  logic             spi_fin,
   output logic             accept,
   output logic             issue,
   output logic [IDX_W-1:0] idx,
   output logic             busy,
   output logic             done
);
   typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_GAP} st_e;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WRITES - 1);

   st_e            st;
   logic [GCW-1:0] gcnt;

   assign accept = start && (st == S_IDLE);
   assign issue  = (st == S_SEND);
   assign busy   = (st != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         idx  <= '0;
         gcnt <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            S_IDLE: if (start) begin
               idx <= '0;
               st  <= S_SEND;
            end
            S_SEND: st <= S_WAIT;
            S_WAIT: if (spi_fin) begin
               if (idx == LAST_IDX) begin
                  done <= 1'b1;
                  st   <= S_IDLE;
               end else begin
                  idx  <= idx + IDX_W'(1);
                  gcnt <= gap_cyc;
                  st   <= S_GAP;
               end
            end
            default: begin
               if (gcnt <= GCW'(1)) st <= S_SEND;
               else gcnt <= gcnt - GCW'(1);
            end
         endcase
      end
   end
endmodule

// File: rtl/csync_seq.sv
module csync_seq
   import csync_pkg::*;
#(
   parameter int         NUM_OUT  = 8,
   parameter int         DIV_W    = 4,
   parameter int         GAP_W    = 4,
   parameter logic [7:0] SYNC_RST = 8'h80,
   parameter logic [7:0] SREF_RST = 8'h44,
   parameter logic [7:0] SDIS_RST = 8'hFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [NUM_OUT-1:0] out_mask,
   input  logic [1:0]         sref_mode,
   input  logic [DIV_W-1:0]   sclk_div,
   input  logic [GAP_W-1:0]   gap_len,
   output logic               spi_sclk,
   output logic               spi_csn,
   output logic               spi_mosi,
   output logic               busy,
   output logic               done
);
   localparam int GCW = GAP_W + DIV_W + 1;

   if (NUM_OUT < 1 || NUM_OUT > 8) begin : g_bad_nout
      $error("csync_seq: NUM_OUT must be 1..8");
   end
   if (DIV_W < 1 || GAP_W < 1) begin : g_bad_width
      $error("csync_seq: DIV_W and GAP_W must be at least 1");
   end

   logic               accept, issue, spi_fin;
   logic [IDX_W-1:0]   idx;
   logic [NUM_OUT-1:0] mask_q;
   logic [1:0]         mode_q;
   logic [DIV_W-1:0]   div_q;
   logic [GAP_W-1:0]   gap_q;
   logic [7:0]         mask8;
   logic [7:0]         sh_sync, sh_sref, sh_sdis;
   reg_sel_e           sel;
   logic [7:0]         wdata;
   logic [ADDR_W-1:0]  waddr;
   logic [GCW-1:0]     gap_cyc;
   logic [DIV_W-1:0]   h1;
   logic [GAP_W-1:0]   g1;

   if (NUM_OUT < 8) begin : g_pad
      assign mask8 = {{(8-NUM_OUT){1'b0}}, mask_q};
   end else begin : g_full
      assign mask8 = mask_q[7:0];
   end

   assign h1      = (div_q == '0) ? DIV_W'(1) : div_q;
   assign g1      = (gap_q == '0) ? GAP_W'(1) : gap_q;
   assign gap_cyc = (GCW'(g1) * GCW'(h1)) << 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         mode_q <= '0;
         div_q  <= '0;
         gap_q  <= '0;
      end else if (accept) begin
         mask_q <= out_mask;
         mode_q <= sref_mode;
         div_q  <= sclk_div;
         gap_q  <= gap_len;
      end
   end

   // step table: which register and which new byte for each write
   always_comb begin
      sel   = REG_SYNC;
      wdata = sh_sync;
      case (idx)
         4'd0: wdata = (sh_sync & ~(SY_MODE_MASK | SY_POL | SY_EN)) | SY_MODE_PIN | SY_EN;
         4'd1: begin sel = REG_SREF; wdata = sh_sref & ~(SR_MUX_MASK | SR_PD); end
         4'd2: wdata = sh_sync | SY_DCLR;
         4'd3: begin sel = REG_SDIS; wdata = sh_sdis & ~mask8; end
         4'd4: wdata = sh_sync | SY_POL;
         4'd5: wdata = sh_sync & ~SY_POL;
         4'd6: begin sel = REG_SDIS; wdata = sh_sdis | mask8; end
         4'd7: wdata = sh_sync & ~SY_DCLR;
         default: begin sel = REG_SREF; wdata = (sh_sref & ~SR_MUX_MASK) | {6'd0, mode_q}; end
      endcase
      case (sel)
         REG_SREF: waddr = ADDR_SREF;
         REG_SDIS: waddr = ADDR_SDIS;
         default:  waddr = ADDR_SYNC;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_sync <= SYNC_RST;
         sh_sref <= SREF_RST;
         sh_sdis <= SDIS_RST;
      end else if (issue) begin
         case (sel)
            REG_SREF: sh_sref <= wdata;
            REG_SDIS: sh_sdis <= wdata;
            default:  sh_sync <= wdata;
         endcase
      end
   end

   csync_step_ctrl #(.GCW(GCW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .gap_cyc(gap_cyc),
      .spi_fin(spi_fin), .accept(accept), .issue(issue), .idx(idx),
      .busy(busy), .done(done)
   );

   csync_spi_shift #(.DIV_W(DIV_W)) u_spi (
      .clk(clk), .rst_n(rst_n), .go(issue), .word({1'b0, waddr, wdata}),
      .half_div(div_q), .sclk(spi_sclk), .csn(spi_csn), .mosi(spi_mosi),
      .fin(spi_fin)
   );
endmodule

// File: rtl/csync_seq_chk.sv
module csync_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic spi_sclk,
   input logic spi_csn,
   input logic spi_mosi,
   input logic busy,
   input logic done
);
   p_rw_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_csn) |-> !spi_mosi);
   p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_csn |-> !spi_sclk);
   p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> $stable(spi_mosi));
   p_start_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   p_csn_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_csn |-> busy);
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind csync_seq csync_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .spi_sclk(spi_sclk),
   .spi_csn(spi_csn), .spi_mosi(spi_mosi), .busy(busy), .done(done)
);

// File: tb/csync_seq_tb.sv
`timescale 1ns/1ps
module csync_seq_tb;
   localparam int NUM_OUT = 8;
   localparam int DIV_W   = 4;
   localparam int GAP_W   = 4;
   // vector: {mask[7:0], mode[1:0], div[3:0], gap[3:0]}
   localparam logic [17:0] VEC [4] = '{
      {8'h05, 2'd3, 4'd1, 4'd1},
      {8'hFF, 2'd2, 4'd2, 4'd0},
      {8'h80, 2'd1, 4'd3, 4'd2},
      {8'h00, 2'd3, 4'd0, 4'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [NUM_OUT-1:0] out_mask = '0;
   logic [1:0] sref_mode = '0;
   logic [DIV_W-1:0] sclk_div = '0;
   logic [GAP_W-1:0] gap_len = '0;
   logic spi_sclk, spi_csn, spi_mosi, busy, done;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] ms = 8'h80, mr = 8'h44, md = 8'hFF;
   logic [23:0] exp_w [9];
   logic [23:0] cap_w [32];
   int cap_b [32];
   int cap_n = 0;
   int nb = 0;
   logic [23:0] mon_sh = '0;
   realtime last_rise = 0.0;
   realtime min_gap = 1.0e9;

   always #2.5 clk = ~clk;

   csync_seq #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W), .GAP_W(GAP_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .out_mask(out_mask),
      .sref_mode(sref_mode), .sclk_div(sclk_div), .gap_len(gap_len),
      .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
      .busy(busy), .done(done)
   );

   // SPI monitor
   always @(posedge spi_sclk) if (spi_csn === 1'b0) begin
      mon_sh = {mon_sh[22:0], spi_mosi};
      nb = nb + 1;
   end
   always @(negedge spi_csn) begin
      if (cap_n > 0 && ($realtime - last_rise) < min_gap) min_gap = $realtime - last_rise;
      nb = 0;
      mon_sh = '0;
   end
   always @(posedge spi_csn) if (nb != 0 && cap_n < 32) begin
      cap_w[cap_n] = mon_sh;
      cap_b[cap_n] = nb;
      cap_n = cap_n + 1;
      last_rise = $realtime;
      nb = 0;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic build_exp(input logic [7:0] m, input logic [1:0] mode);
      ms = (ms & 8'hF0) | 8'h09;          exp_w[0] = {1'b0, 15'h0140, ms};
      mr = mr & 8'hF8;                    exp_w[1] = {1'b0, 15'h0141, mr};
      ms = ms | 8'h10;                    exp_w[2] = {1'b0, 15'h0140, ms};
      md = md & ~m;                       exp_w[3] = {1'b0, 15'h0142, md};
      ms = ms | 8'h04;                    exp_w[4] = {1'b0, 15'h0140, ms};
      ms = ms & ~8'h04;                   exp_w[5] = {1'b0, 15'h0140, ms};
      md = md | m;                        exp_w[6] = {1'b0, 15'h0142, md};
      ms = ms & ~8'h10;                   exp_w[7] = {1'b0, 15'h0140, ms};
      mr = (mr & 8'hFC) | {6'd0, mode};   exp_w[8] = {1'b0, 15'h0141, mr};
   endtask

   function automatic string word_tag(input int i);
      case (i)
         3, 6:    return "R5";
         4, 5:    return "R6";
         8:       return "R7";
         default: return "R3";
      endcase
   endfunction

   // waits for done, checks busy/done behaviour (R9)
   task automatic wait_done();
      int cyc = 0;
      while (done !== 1'b1 && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done === 1'b1, "R9", "done seen", done, 1);
      chk(busy === 1'b0, "R9", "busy low with done", busy, 0);
      @(negedge clk);
      chk(done === 1'b0, "R9", "done one cycle", done, 0);
   endtask

   task automatic check_words(input int div, input int gap);
      int h = (div == 0) ? 1 : div;
      int g = (gap == 0) ? 1 : gap;
      chk(cap_n == 9, "R3", "write count", cap_n, 9);
      for (int i = 0; i < 9; i++) begin
         chk(cap_w[i] === exp_w[i], word_tag(i), $sformatf("word %0d (R4 shadow)", i), cap_w[i], exp_w[i]);
         chk(cap_b[i] == 24, "R2", $sformatf("sclk count word %0d", i), cap_b[i], 24);
      end
      chk(cap_w[0][23] == 1'b0 && cap_w[0][22:8] == 15'h0140, "R1", "frame header",
          cap_w[0][23:8], 16'h0140);
      chk(min_gap >= real'(g * 2 * h) * 5.0, "R10", "inter-write gap ns",
          int'(min_gap), g * 2 * h * 5);
   endtask

   task automatic launch(input logic [17:0] v);
      cap_n = 0;
      min_gap = 1.0e9;
      @(negedge clk);
      out_mask  = v[17:10];
      sref_mode = v[9:8];
      sclk_div  = v[7:4];
      gap_len   = v[3:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R9", "busy after start", busy, 1);
   endtask

   initial begin
      #(2_000_000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(busy === 1'b0, "R11", "busy in reset", busy, 0);
      chk(done === 1'b0, "R11", "done in reset", done, 0);
      chk(spi_csn === 1'b1, "R11", "csn in reset", spi_csn, 1);
      chk(spi_sclk === 1'b0, "R11", "sclk in reset", spi_sclk, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table of runs; shadows carry over between runs (R4)
      for (int k = 0; k < 4; k++) begin
         launch(VEC[k]);
         build_exp(VEC[k][17:10], VEC[k][9:8]);
         wait_done();
         check_words(int'(VEC[k][7:4]), int'(VEC[k][3:0]));
         // R4: unowned top bit of sync control still from reset value
         chk(cap_w[0][7] === 1'b1, "R4", "kept sync bit 7", cap_w[0][7], 1);
      end

      // R8: start while busy is ignored, inputs captured at accept
      launch({8'h3C, 2'd2, 4'd1, 4'd1});
      build_exp(8'h3C, 2'd2);
      while (cap_n < 3) @(negedge clk);
      out_mask = 8'h0F;
      sref_mode = 2'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check_words(1, 1);
      repeat (1000) @(negedge clk);
      chk(cap_n == 9, "R8", "no extra frames after ignored start", cap_n, 9);
      chk(busy === 1'b0, "R8", "idle after ignored start", busy, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule